// File: doc/BRIEF.md
# Cache Configuration and Event Counter Register Space

This block gives a cache a small memory-mapped register space of its own. The space is a 4 KiB window whose base comes from an input port, so the window can be placed anywhere on a 4 KiB boundary. Every request on the request port whose address lies in the window is claimed and decoded as an aligned 64-bit register access. Requests outside the window are left for other targets.

Inside the window are three read-only words: an identification word and two words that describe the cache geometry, computed from parameters. Two read/write words hold the cache-controller options and the write-buffer options, and their fields drive the control outputs. A bank of thirteen 64-bit event counters follows. Each counter advances on its own event strobe, but only while the counter-enable field is set. Software can write a counter to clear or preset it. The counter bank can be removed by a parameter. Any access to its region then gets an error response.

A response comes one cycle after a claimed request that asked for one. It carries read data and an error flag.

Top module: `cache_csr_space`

## Requirements
- R1: `req_hit_o` is high in the same cycle as `req_valid_i` when address bits [PA_W-1:12] equal `base_i[PA_W-1:12]` and address bits [2:0] are zero. Any other request is not claimed: it gets no response and changes no register.
- R2: A read of offset 0x000 returns 0x0001_0001_0001_0001. That is four 16-bit identification fields, each equal to 1.
- R3: A read of offset 0x008 returns:
  - sets-1 in [15:0];
  - ways-1 in [23:16];
  - log2(line bytes) in [27:24];
  - MSHR sets-1 in [39:32];
  - MSHR ways-1 in [47:40];
  - zero in all other bits.
  With the default parameters this is 0x0000_011F_0607_003F.
- R4: A read of offset 0x010 returns:
  - replay-table entries-1 in [7:0];
  - write-buffer directory entries-1 in [23:16];
  - write-buffer data entries-1 in [31:24];
  - log2(write-buffer entry bytes) in [35:32];
  - zero in all other bits.
  With the default parameters this is 0x0000_0003_030F_0007.
- R5: The word at offset 0x018 holds three fields. Cache enable is bit 0 and resets to 0. Counter enable is bit 8 and resets to 1. Single-entry replay mode is bit 56 and resets to 0. A write loads exactly these bits, all other bits read zero, and `cache_en_o`, `cnt_en_o` and `rtab_single_o` show the stored fields.
- R6: The word at offset 0x020 holds four fields. Reset-timer-on-write is bit 0 and resets to 1. Sequential write-after-write is bit 1 and resets to 0. Inhibit-coalescing is bit 2 and resets to 0. The timer threshold is [15:8] and resets to 3. The register resets to 0x301, other bits read zero, and the `wb_*` outputs show the fields.
- R7: Writes to offsets 0x000–0x010 and to unmapped offsets change nothing and do not report an error. Reads of unmapped offsets return zero without error.
- R8: A claimed request with `req_need_rsp_i` high gets `rsp_valid_o` in the next cycle. A claimed request with `req_need_rsp_i` low gets no response. The response data of a write is zero.
- R9: The counter at offset 0x100+8k is 64 bits wide. It adds one on `evt_i[k]` only while counter enable (R5 bit 8) is 1, and it wraps from all ones to zero. Offsets 0x168–0x1F8 read zero.
- R10: If a software write and an event hit the same counter in the same cycle, the counter takes the written value.
- R11: Event bits k=0..12 map to these counters, in order:
  - writes;
  - reads;
  - prefetches;
  - uncached requests;
  - cache-maintenance requests;
  - all requests;
  - write misses;
  - read misses;
  - holds;
  - holds on MSHR conflict;
  - holds on write-buffer conflict;
  - re-holds after rollback;
  - stall cycles.
- R12: With HAS_PERF=0, any claimed access to offsets 0x100–0x1FF is ignored. If a response was asked for, it has `rsp_err_o`=1 and data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_i | input | PA_W | Window base; low 12 bits are expected to be zero |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | PA_W | Request byte address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 64 | Write data |
| req_need_rsp_i | input | 1 | Request wants a response |
| req_hit_o | output | 1 | Request is claimed by this window |
| rsp_valid_o | output | 1 | Response present |
| rsp_data_o | output | 64 | Response read data |
| rsp_err_o | output | 1 | Response reports an error |
| evt_i | input | 13 | One event strobe per counter |
| cache_en_o | output | 1 | Cache enable field |
| cnt_en_o | output | 1 | Counter enable field |
| rtab_single_o | output | 1 | Single-entry replay mode field |
| wb_rst_timer_o | output | 1 | Restart entry timer on write |
| wb_seq_waw_o | output | 1 | Serialise colliding writes |
| wb_no_coalesce_o | output | 1 | Inhibit write coalescing |
| wb_threshold_o | output | 8 | Write-buffer timer threshold |

## Verification
The assertions assume that `base_i` stays constant between a request and its response. This is needed because the claim check and the read-data check both refer to the address seen one cycle earlier. They also assume that a request is presented for a single cycle, and that the low 12 bits of `base_i` are zero. The bench holds the base at one aligned value for the whole run. It presents a fresh, independently drawn request every cycle, so a request is never held over into the next cycle. Out-of-window and misaligned addresses are made by flipping a single upper address bit or the low three bits, never by moving the base.

// File: rtl/ccsr_pkg.sv
package ccsr_pkg;

   // number of event counters and word index of the first one
   localparam int NUM_EVT      = 13;
   localparam int CNT_BASE_IDX = 32;

   // word indexes (byte offset / 8) of the fixed registers
   localparam logic [8:0] IDX_IDENT  = 9'd0;
   localparam logic [8:0] IDX_GEOM0  = 9'd1;
   localparam logic [8:0] IDX_GEOM1  = 9'd2;
   localparam logic [8:0] IDX_CCTRL  = 9'd3;
   localparam logic [8:0] IDX_WBCTRL = 9'd4;

   localparam logic [63:0] IDENT_WORD = 64'h0001_0001_0001_0001;

   // event strobe positions
   typedef enum int unsigned {
      EV_WRITE, EV_READ, EV_PREFETCH, EV_UNCACHED, EV_CMO, EV_ANY,
      EV_WR_MISS, EV_RD_MISS, EV_HOLD, EV_HOLD_MSHR, EV_HOLD_WBUF,
      EV_REHOLD, EV_STALL
   } evt_e;

   typedef struct packed {
      logic rtab_single;
      logic cnt_en;
      logic cache_en;
   } cctrl_t;

   typedef struct packed {
      logic [7:0] thresh;
      logic       no_coalesce;
      logic       seq_waw;
      logic       rst_timer;
   } wbctrl_t;

   localparam cctrl_t  CCTRL_RST  = '{rtab_single: 1'b0, cnt_en: 1'b1, cache_en: 1'b0};
   localparam wbctrl_t WBCTRL_RST = '{thresh: 8'd3, no_coalesce: 1'b0, seq_waw: 1'b0, rst_timer: 1'b1};

endpackage

// File: rtl/ccsr_decode.sv
module ccsr_decode #(
   parameter int PA_W = 40
) (
   input  logic [PA_W-1:0] base_i,
   input  logic            valid_i,
   input  logic [PA_W-1:0] addr_i,
   output logic            hit_o,
   output logic [8:0]      idx_o,
   output logic            cnt_region_o
);
   logic in_window;
   logic aligned;
   logic unused_base;

   assign in_window    = (addr_i[PA_W-1:12] == base_i[PA_W-1:12]);
   assign aligned      = (addr_i[2:0] == 3'b000);
   assign hit_o        = valid_i && in_window && aligned;
   assign idx_o        = addr_i[11:3];
   assign cnt_region_o = (addr_i[11:8] == 4'h1);
   assign unused_base  = ^base_i[11:0];
endmodule

// File: rtl/ccsr_ctrl_regs.sv
module ccsr_ctrl_regs
   import ccsr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_cctrl_i,
   input  logic        wr_wbctrl_i,
   input  logic [63:0] wdata_i,
   output cctrl_t      cctrl_q,
   output wbctrl_t     wbctrl_q
);
   logic unused_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cctrl_q <= CCTRL_RST;
      end else if (wr_cctrl_i) begin
         cctrl_q.cache_en    <= wdata_i[0];
         cctrl_q.cnt_en      <= wdata_i[8];
         cctrl_q.rtab_single <= wdata_i[56];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbctrl_q <= WBCTRL_RST;
      end else if (wr_wbctrl_i) begin
         wbctrl_q.rst_timer   <= wdata_i[0];
         wbctrl_q.seq_waw     <= wdata_i[1];
         wbctrl_q.no_coalesce <= wdata_i[2];
         wbctrl_q.thresh      <= wdata_i[15:8];
      end
   end

   assign unused_wdata = ^{wdata_i[63:57], wdata_i[55:16], wdata_i[7:3]};
endmodule

// File: rtl/ccsr_evt_bank.sv
module ccsr_evt_bank #(
   parameter int N        = 13,
   parameter int W        = 64,
   parameter bit HAS_PERF = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cnt_en_i,
   input  logic [N-1:0]        evt_i,
   input  logic [N-1:0]        wr_sel_i,
   input  logic [W-1:0]        wdata_i,
   output logic [N-1:0][W-1:0] cnt_o
);
   generate
      if (HAS_PERF) begin : g_counters
         logic [W-1:0] cnt_r [N];
         for (genvar g = 0; g < N; g++) begin : g_cnt
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  cnt_r[g] <= '0;
               end else if (wr_sel_i[g]) begin
                  cnt_r[g] <= wdata_i;
               end else if (cnt_en_i && evt_i[g]) begin
                  cnt_r[g] <= cnt_r[g] + W'(1);
               end
            end
            assign cnt_o[g] = cnt_r[g];
         end
      end else begin : g_no_counters
         logic unused_in;
         assign cnt_o     = '0;
         assign unused_in = ^{clk, rst_n, cnt_en_i, evt_i, wr_sel_i, wdata_i};
      end
   endgenerate
endmodule

// File: rtl/cache_csr_space.sv
module cache_csr_space
   import ccsr_pkg::*;
#(
   parameter int PA_W        = 40,
   parameter int CNT_W       = 64,
   parameter int SETS        = 64,
   parameter int WAYS        = 8,
   parameter int CL_BITS     = 512,
   parameter int MSHR_SETS   = 32,
   parameter int MSHR_WAYS   = 2,
   parameter int RTAB_N      = 8,
   parameter int WBUF_DIR_N  = 16,
   parameter int WBUF_DATA_N = 4,
   parameter int WBUF_BITS   = 64,
   parameter bit HAS_PERF    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PA_W-1:0]    base_i,
   input  logic               req_valid_i,
   input  logic [PA_W-1:0]    req_addr_i,
   input  logic               req_we_i,
   input  logic [63:0]        req_wdata_i,
   input  logic               req_need_rsp_i,
   output logic               req_hit_o,
   output logic               rsp_valid_o,
   output logic [63:0]        rsp_data_o,
   output logic               rsp_err_o,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               cache_en_o,
   output logic               cnt_en_o,
   output logic               rtab_single_o,
   output logic               wb_rst_timer_o,
   output logic               wb_seq_waw_o,
   output logic               wb_no_coalesce_o,
   output logic [7:0]         wb_threshold_o
);
   localparam int CL_LOG   = $clog2(CL_BITS / 8);
   localparam int WBUF_LOG = $clog2(WBUF_BITS / 8);

   localparam logic [63:0] GEOM0_WORD = {16'd0, 8'(MSHR_WAYS - 1), 8'(MSHR_SETS - 1),
                                         4'd0, 4'(CL_LOG), 8'(WAYS - 1), 16'(SETS - 1)};
   localparam logic [63:0] GEOM1_WORD = {28'd0, 4'(WBUF_LOG), 8'(WBUF_DATA_N - 1),
                                         8'(WBUF_DIR_N - 1), 8'd0, 8'(RTAB_N - 1)};

   // elaboration-time parameter checks
   generate
      if (PA_W <= 12) begin : g_bad_pa
         $error("PA_W must exceed the 12-bit window offset");
      end
      if (CNT_W < 1 || CNT_W > 64) begin : g_bad_cnt
         $error("CNT_W must be 1..64");
      end
      if (CL_BITS < 8 || (CL_BITS & (CL_BITS - 1)) != 0) begin : g_bad_cl
         $error("CL_BITS must be a power of two of at least 8");
      end
      if (WBUF_BITS < 8 || (WBUF_BITS & (WBUF_BITS - 1)) != 0) begin : g_bad_wb
         $error("WBUF_BITS must be a power of two of at least 8");
      end
      if (SETS < 1 || SETS > 65536 || WAYS < 1 || WAYS > 256) begin : g_bad_geom
         $error("SETS or WAYS out of field range");
      end
      if (MSHR_SETS < 1 || MSHR_SETS > 256 || MSHR_WAYS < 1 || MSHR_WAYS > 256) begin : g_bad_mshr
         $error("MSHR geometry out of field range");
      end
      if (RTAB_N < 1 || RTAB_N > 256 || WBUF_DIR_N < 1 || WBUF_DIR_N > 256 ||
          WBUF_DATA_N < 1 || WBUF_DATA_N > 256) begin : g_bad_tab
         $error("table sizes out of field range");
      end
      if (CNT_BASE_IDX + NUM_EVT > 64) begin : g_bad_map
         $error("counter bank overruns its region");
      end
   endgenerate

   logic        hit;
   logic [8:0]  idx;
   logic        cnt_region;
   logic        wr_hit;
   cctrl_t      cctrl_q;
   wbctrl_t     wbctrl_q;
   logic [NUM_EVT-1:0]            cnt_wr_sel;
   logic [NUM_EVT-1:0][CNT_W-1:0] cnt_q;
   logic [63:0] rd_data;
   logic        rd_err;
   logic [63:0] cctrl_word;
   logic [63:0] wbctrl_word;

   ccsr_decode #(.PA_W(PA_W)) u_decode (
      .base_i      (base_i),
      .valid_i     (req_valid_i),
      .addr_i      (req_addr_i),
      .hit_o       (hit),
      .idx_o       (idx),
      .cnt_region_o(cnt_region)
   );

   assign wr_hit = hit && req_we_i;

   ccsr_ctrl_regs u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cctrl_i (wr_hit && (idx == IDX_CCTRL)),
      .wr_wbctrl_i(wr_hit && (idx == IDX_WBCTRL)),
      .wdata_i    (req_wdata_i),
      .cctrl_q    (cctrl_q),
      .wbctrl_q   (wbctrl_q)
   );

   generate
      for (genvar k = 0; k < NUM_EVT; k++) begin : g_wsel
         assign cnt_wr_sel[k] = wr_hit && cnt_region && (idx[4:0] == 5'(k));
      end
   endgenerate

   ccsr_evt_bank #(.N(NUM_EVT), .W(CNT_W), .HAS_PERF(HAS_PERF)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en_i(cctrl_q.cnt_en),
      .evt_i   (evt_i),
      .wr_sel_i(cnt_wr_sel),
      .wdata_i (req_wdata_i[CNT_W-1:0]),
      .cnt_o   (cnt_q)
   );

   always_comb begin
      cctrl_word      = '0;
      cctrl_word[0]   = cctrl_q.cache_en;
      cctrl_word[8]   = cctrl_q.cnt_en;
      cctrl_word[56]  = cctrl_q.rtab_single;
      wbctrl_word     = '0;
      wbctrl_word[0]  = wbctrl_q.rst_timer;
      wbctrl_word[1]  = wbctrl_q.seq_waw;
      wbctrl_word[2]  = wbctrl_q.no_coalesce;
      wbctrl_word[15:8] = wbctrl_q.thresh;
   end

   always_comb begin
      rd_data = '0;
      rd_err  = 1'b0;
      if (cnt_region) begin
         if (HAS_PERF) begin
            for (int k = 0; k < NUM_EVT; k++) begin
               if (idx[4:0] == 5'(k)) rd_data = 64'(cnt_q[k]);
            end
         end else begin
            rd_err = 1'b1;
         end
      end else begin
         case (idx)
            IDX_IDENT:  rd_data = IDENT_WORD;
            IDX_GEOM0:  rd_data = GEOM0_WORD;
            IDX_GEOM1:  rd_data = GEOM1_WORD;
            IDX_CCTRL:  rd_data = cctrl_word;
            IDX_WBCTRL: rd_data = wbctrl_word;
            default:    rd_data = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_data_o  <= '0;
         rsp_err_o   <= 1'b0;
      end else begin
         rsp_valid_o <= hit && req_need_rsp_i;
         rsp_data_o  <= (hit && req_need_rsp_i && !req_we_i) ? rd_data : 64'd0;
         rsp_err_o   <= hit && req_need_rsp_i && rd_err;
      end
   end

   assign req_hit_o        = hit;
   assign cache_en_o       = cctrl_q.cache_en;
   assign cnt_en_o         = cctrl_q.cnt_en;
   assign rtab_single_o    = cctrl_q.rtab_single;
   assign wb_rst_timer_o   = wbctrl_q.rst_timer;
   assign wb_seq_waw_o     = wbctrl_q.seq_waw;
   assign wb_no_coalesce_o = wbctrl_q.no_coalesce;
   assign wb_threshold_o   = wbctrl_q.thresh;
endmodule

// File: rtl/ccsr_checker.sv
module ccsr_checker
   import ccsr_pkg::*;
#(
   parameter int PA_W     = 40,
   parameter bit HAS_PERF = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PA_W-1:0] base_i,
   input logic            req_valid_i,
   input logic [PA_W-1:0] req_addr_i,
   input logic            req_we_i,
   input logic            req_need_rsp_i,
   input logic            req_hit_o,
   input logic            rsp_valid_o,
   input logic [63:0]     rsp_data_o,
   input logic            rsp_err_o,
   input logic            cache_en_o,
   input logic            cnt_en_o,
   input logic            rtab_single_o,
   input logic            wb_rst_timer_o,
   input logic            wb_seq_waw_o,
   input logic            wb_no_coalesce_o,
   input logic [7:0]      wb_threshold_o
);
   logic claim_rsp;
   logic claim_wr;
   assign claim_rsp = req_valid_i && req_hit_o && req_need_rsp_i;
   assign claim_wr  = req_valid_i && req_hit_o && req_we_i;

   assert_claim_inside_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_hit_o |-> (req_valid_i && req_addr_i[PA_W-1:12] == base_i[PA_W-1:12]
                     && req_addr_i[2:0] == 3'b000));

   assert_outside_unclaimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_addr_i[PA_W-1:12] != base_i[PA_W-1:12]) |-> !req_hit_o);

   assert_ident_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rsp && !req_we_i && req_addr_i[11:3] == 9'd0) |=> (rsp_data_o == IDENT_WORD));

   assert_cctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !claim_wr |=> $stable({cache_en_o, cnt_en_o, rtab_single_o}));

   assert_wbctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !claim_wr |=> $stable({wb_rst_timer_o, wb_seq_waw_o, wb_no_coalesce_o, wb_threshold_o}));

   assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      claim_rsp |=> rsp_valid_o);

   assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !claim_rsp |=> !rsp_valid_o);

   assert_write_rsp_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rsp && req_we_i) |=> (rsp_data_o == 64'd0));

   assert_err_with_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err_o |-> (rsp_valid_o && $past(req_addr_i[11:8]) == 4'h1 && !HAS_PERF));
endmodule

bind cache_csr_space ccsr_checker #(.PA_W(PA_W), .HAS_PERF(HAS_PERF)) u_ccsr_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .base_i          (base_i),
   .req_valid_i     (req_valid_i),
   .req_addr_i      (req_addr_i),
   .req_we_i        (req_we_i),
   .req_need_rsp_i  (req_need_rsp_i),
   .req_hit_o       (req_hit_o),
   .rsp_valid_o     (rsp_valid_o),
   .rsp_data_o      (rsp_data_o),
   .rsp_err_o       (rsp_err_o),
   .cache_en_o      (cache_en_o),
   .cnt_en_o        (cnt_en_o),
   .rtab_single_o   (rtab_single_o),
   .wb_rst_timer_o  (wb_rst_timer_o),
   .wb_seq_waw_o    (wb_seq_waw_o),
   .wb_no_coalesce_o(wb_no_coalesce_o),
   .wb_threshold_o  (wb_threshold_o)
);

// File: tb/test_cache_csr_space.sv
`timescale 1ns/1ps
module test_cache_csr_space;
   localparam logic [39:0] BASE  = 40'h00_1234_5000;
   localparam logic [63:0] IDENT = 64'h0001_0001_0001_0001;
   localparam logic [63:0] GEOM0 = 64'h0000_011F_0607_003F;
   localparam logic [63:0] GEOM1 = 64'h0000_0003_030F_0007;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [39:0] req_addr = '0;
   logic        req_we = 1'b0;
   logic [63:0] req_wdata = '0;
   logic        req_need = 1'b0;
   logic [12:0] evt = '0;

   logic        hit, rsp_valid, rsp_err;
   logic [63:0] rsp_data;
   logic        c_en, c_pe, c_rs, w_rt, w_sq, w_nc;
   logic [7:0]  w_th;
   logic        np_hit, np_valid, np_err;
   logic [63:0] np_data;
   logic        np_en, np_pe, np_rs, np_rt, np_sq, np_nc;
   logic [7:0]  np_th;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   bit          m_en, m_pe, m_rs, m_rt, m_sq, m_nc;
   logic [7:0]  m_th;
   logic [63:0] m_cnt [13];

   always #10 clk = ~clk;

   cache_csr_space i_cache_csr_space (
      .clk(clk), .rst_n(rst_n), .base_i(BASE), .req_valid_i(req_valid),
      .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata),
      .req_need_rsp_i(req_need), .req_hit_o(hit), .rsp_valid_o(rsp_valid),
      .rsp_data_o(rsp_data), .rsp_err_o(rsp_err), .evt_i(evt),
      .cache_en_o(c_en), .cnt_en_o(c_pe), .rtab_single_o(c_rs),
      .wb_rst_timer_o(w_rt), .wb_seq_waw_o(w_sq), .wb_no_coalesce_o(w_nc),
      .wb_threshold_o(w_th));

   cache_csr_space #(.HAS_PERF(1'b0)) i_cache_csr_space_noperf (
      .clk(clk), .rst_n(rst_n), .base_i(BASE), .req_valid_i(req_valid),
      .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata),
      .req_need_rsp_i(req_need), .req_hit_o(np_hit), .rsp_valid_o(np_valid),
      .rsp_data_o(np_data), .rsp_err_o(np_err), .evt_i(evt),
      .cache_en_o(np_en), .cnt_en_o(np_pe), .rtab_single_o(np_rs),
      .wb_rst_timer_o(np_rt), .wb_seq_waw_o(np_sq), .wb_no_coalesce_o(np_nc),
      .wb_threshold_o(np_th));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [63:0] model_read(input logic [8:0] i);
      logic [63:0] w;
      w = '0;
      if (i[8:5] == 4'h1) begin
         if (i[4:0] < 5'd13) w = m_cnt[i[4:0]];
      end else begin
         case (i)
            9'd0: w = IDENT;
            9'd1: w = GEOM0;
            9'd2: w = GEOM1;
            9'd3: begin w[0] = m_en; w[8] = m_pe; w[56] = m_rs; end
            9'd4: begin w[0] = m_rt; w[1] = m_sq; w[2] = m_nc; w[15:8] = m_th; end
            default: w = '0;
         endcase
      end
      return w;
   endfunction

   task automatic check_ctrl();
      chk({c_en, c_pe, c_rs} == {m_en, m_pe, m_rs}, "R5 ctrl outputs",
          64'({c_en, c_pe, c_rs}), 64'({m_en, m_pe, m_rs}));
      chk({w_rt, w_sq, w_nc, w_th} == {m_rt, m_sq, m_nc, m_th}, "R6 wbuf outputs",
          64'({w_rt, w_sq, w_nc, w_th}), 64'({m_rt, m_sq, m_nc, m_th}));
   endtask

   // one request cycle; called and returns at a falling edge
   task automatic step(input bit v, input logic [39:0] a, input bit w, input logic [63:0] d,
                       input bit n, input logic [12:0] e, input string tag);
      bit          exp_hit, exp_rsp, region, pe_now;
      logic [8:0]  i;
      logic [63:0] ed;
      string       t;
      req_valid = v; req_addr = a; req_we = w; req_wdata = d; req_need = n; evt = e;
      #1;
      exp_hit = v && (a[39:12] == BASE[39:12]) && (a[2:0] == 3'b000);
      chk(hit == exp_hit, "R1 claim", 64'(hit), 64'(exp_hit));
      i = a[11:3];
      region = (i[8:5] == 4'h1);
      exp_rsp = exp_hit && n;
      ed = w ? 64'd0 : model_read(i);
      if (tag != "") t = tag;
      else if (region) t = "R9 counter read";
      else if (i == 9'd0) t = "R2 ident";
      else if (i == 9'd1) t = "R3 geom0";
      else if (i == 9'd2) t = "R4 geom1";
      else if (i == 9'd3) t = "R5 cctrl";
      else if (i == 9'd4) t = "R6 wbctrl";
      else t = "R7 unmapped";
      pe_now = m_pe;
      if (exp_hit && w) begin
         if (i == 9'd3) begin m_en = d[0]; m_pe = d[8]; m_rs = d[56]; end
         if (i == 9'd4) begin m_rt = d[0]; m_sq = d[1]; m_nc = d[2]; m_th = d[15:8]; end
      end
      for (int k = 0; k < 13; k++) begin
         if (exp_hit && w && region && i[4:0] == 5'(k)) m_cnt[k] = d;   // R10
         else if (pe_now && e[k]) m_cnt[k] = m_cnt[k] + 64'd1;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      evt = '0;
      chk(rsp_valid == exp_rsp, "R8 rsp valid", 64'(rsp_valid), 64'(exp_rsp));
      if (exp_rsp) begin
         chk(rsp_data == ed, t, rsp_data, ed);
         chk(rsp_err == 1'b0, "R7 no error", 64'(rsp_err), 64'd0);
      end
      chk(np_valid == exp_rsp, "R12 rsp valid", 64'(np_valid), 64'(exp_rsp));
      if (exp_rsp) begin
         chk(np_err == region, "R12 error flag", 64'(np_err), 64'(region));
         chk(np_data == (region ? 64'd0 : ed), "R12 data", np_data, region ? 64'd0 : ed);
      end
      check_ctrl();
   endtask

   function automatic logic [39:0] at(input int idx);
      return BASE | 40'(idx * 8);
   endfunction

   initial begin
      m_en = 0; m_pe = 1; m_rs = 0; m_rt = 1; m_sq = 0; m_nc = 0; m_th = 8'd3;
      for (int k = 0; k < 13; k++) m_cnt[k] = '0;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check_ctrl();
      chk(rsp_valid == 1'b0, "R8 idle after reset", 64'(rsp_valid), 64'd0);
      for (int r = 0; r < 5; r++) step(1, at(r), 0, 0, 1, '0, "");
      // read-only and unmapped writes ignored
      for (int r = 0; r < 3; r++) step(1, at(r), 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, '0, "R7 ro write");
      step(1, at(9), 1, 64'h1234, 1, '0, "R7 unmapped write");
      for (int r = 0; r < 3; r++) step(1, at(r), 0, 0, 1, '0, "R7 ro readback");
      step(1, at(9), 0, 0, 1, '0, "R7 unmapped read");
      // control field write: only defined bits stick
      step(1, at(3), 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, '0, "R5 write");
      step(1, at(3), 0, 0, 1, '0, "R5 readback all ones");
      step(1, at(4), 1, 64'hFFFF_FFFF_FFFF_A5F8, 1, '0, "R6 write");
      step(1, at(4), 0, 0, 1, '0, "R6 readback");
      // misaligned and outside window: unclaimed
      step(1, at(3) | 40'd4, 1, 64'd0, 1, '0, "R1 misaligned");
      step(1, at(3) ^ 40'h10_0000_0000, 1, 64'd0, 1, '0, "R1 outside");
      step(1, at(3), 0, 0, 1, '0, "R1 state unchanged");
      // counter map: each event bit k hits only counter k
      for (int k = 0; k < 13; k++) begin
         step(1, at(32 + k), 1, 64'd0, 0, '0, "R11 clear");
         step(0, '0, 0, 0, 0, 13'(1 << k), "");
         step(0, '0, 0, 0, 0, 13'(1 << k), "");
         for (int j = 0; j < 13; j++) step(1, at(32 + j), 0, 0, 1, '0, "R11 mapping");
      end
      // counting disabled
      step(1, at(3), 1, 64'd0, 1, '0, "R9 disable");
      for (int r = 0; r < 4; r++) step(0, '0, 0, 0, 0, 13'h1FFF, "");
      step(1, at(32), 0, 0, 1, 13'h1FFF, "R9 frozen while disabled");
      step(1, at(3), 1, 64'h100, 1, '0, "R9 enable");
      // wrap
      step(1, at(32), 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, '0, "R9 preset");
      step(0, '0, 0, 0, 0, 13'h0001, "");
      step(1, at(32), 0, 0, 1, '0, "R9 wrap to zero");
      // write wins over event
      step(1, at(37), 1, 64'h55, 1, 13'h1FFF, "R10 write priority");
      step(1, at(37), 0, 0, 1, '0, "R10 write priority");
      step(1, at(45), 0, 0, 1, '0, "R9 beyond last counter");
      // constrained random
      for (int s = 0; s < 3000; s++) begin
         int unsigned r;
         logic [39:0] a;
         r = $urandom % 16;
         if (r < 5)       a = at($urandom % 5);
         else if (r < 10) a = at(32 + ($urandom % 16));
         else if (r < 12) a = at($urandom % 512);
         else if (r == 12) a = at($urandom % 64) ^ (40'd1 << (12 + ($urandom % 28)));
         else if (r == 13) a = at($urandom % 64) | 40'($urandom % 7 + 1);
         else             a = at(3);
         step(($urandom % 8) != 0, a, ($urandom % 3) == 0,
              {$urandom, $urandom}, ($urandom % 4) != 0, 13'($urandom), "");
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule